// File: doc/BRIEF.md
# Audio Capture Receive FIFO with Interrupt Logic

This block is the receive side of a multi-channel PDM microphone capture path. Converted samples arrive one per cycle on a valid/data input, tagged with the index of the channel that produced them. They are queued in a small FIFO. Software drains the FIFO one word at a time by reading a holding register. A DMA engine can instead use a request line that goes high once a programmable number of words is waiting.

Each word read from the holding register carries a 24-bit signed sample in its low bits and the channel index, zero-extended, in its top byte. Six receive conditions make up an interrupt status vector, and a mask selects which of them drive the single level interrupt line. The mask is changed only through a write-one-to-set register and a write-one-to-clear register. Reading the status register clears its latched error flags. Reading the holding register pops the FIFO. Both of these reads therefore change state.

Top module: `audio_rx_fifo_irq`

## Requirements
- R1: After reset the status reads 0x02 (only the empty bit), the mask reads 0, the mode register reads 0x1000_0000 (chunk of one word), and both `irq` and `dma_req` are low.
- R2: A write to offset 0x14 sets every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. The mask reads back in bits [5:0] at offset 0x1C.
- R3: A write to offset 0x18 clears every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged.
- R4: The status register at offset 0x20 has these bits: bit 0 data available, bit 1 FIFO empty, bit 2 FIFO full, bit 3 chunk reached, bit 4 underrun, bit 5 overrun. `irq` is high exactly when some status bit is 1 and its mask bit is also 1.
- R5: A read of offset 0x0C returns the oldest stored word as {channel index zero-extended to 8 bits, 24-bit sample} and removes that word from the FIFO. Words come out in arrival order.
- R6: The FIFO holds 16 words. After 16 pushes the full bit is set, and 16 holding reads return all 16 words and leave the FIFO empty.
- R7: A sample pushed while the FIFO is full and no holding read happens in that cycle is dropped, and overrun (bit 4 of R4's list is underrun; overrun is bit 5) is set. If a holding read happens in the same cycle, the push is accepted and overrun is not set.
- R8: A holding read while the FIFO is empty returns 0 and sets underrun (bit 4). A sample pushed in that same cycle is still stored.
- R9: A status read returns the current flags and then clears underrun and overrun. An overrun event in the same cycle as the status read stays set.
- R10: Mode bits [31:28] hold the chunk size in words, and the value 0 acts as 1. `dma_req` and status bit 3 are high while the stored word count is at least the chunk size. The mode register reads back only this field; all its other bits read 0.
- R11: Writing 1 to bit 0 of offset 0x00 empties the FIFO and clears underrun and overrun in the next cycle. The mask and the chunk size are kept.
- R12: Offset 0x50 returns the `VERSION` parameter in bits [11:0]. Offsets that map to no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_chan | input | CH_W | Channel index of the sample |
| smp_data | input | SMP_W | Signed sample value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; the read side effects take effect at the clock edge |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the same cycle as the strobe |
| dma_req | output | 1 | Stored word count has reached the chunk size |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a depth of 16, 24-bit samples and a 2-bit channel index. This means a complete fill, the push beyond full and the full 16-read drain all fit in a short run. All four channel indices can appear in the tag byte, and every chunk size up to 8 can be compared against real counts. Because the depth is a power of two, the pointer wrap is exercised: after the overrun test the FIFO is refilled across the wrap point. The bench also covers the same-cycle push-and-pop corner on both a full FIFO and an empty FIFO.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_HOLD = 8'h0C;
  localparam logic [7:0] OFS_IEN  = 8'h14;
  localparam logic [7:0] OFS_IDIS = 8'h18;
  localparam logic [7:0] OFS_IMSK = 8'h1C;
  localparam logic [7:0] OFS_ISTS = 8'h20;
  localparam logic [7:0] OFS_VER  = 8'h50;

  localparam int NUM_EVT   = 6;
  localparam int EV_READY  = 0;
  localparam int EV_EMPTY  = 1;
  localparam int EV_FULL   = 2;
  localparam int EV_CHUNK  = 3;
  localparam int EV_UNDER  = 4;
  localparam int EV_OVER   = 5;

  // bits that latch an event pulse; the others follow a live condition
  localparam logic [NUM_EVT-1:0] EV_LATCHED = 6'b110000;

  localparam int CHUNK_LSB = 28;
  localparam int CHUNK_W   = 4;
endpackage

// File: rtl/arx_fifo.sv
module arx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             underflow
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          do_push, do_pop;

  assign count = count_q;
  assign empty = (count_q == '0);
  assign full  = (count_q == CW'(DEPTH));

  // a pop frees a slot in the same cycle, so a full FIFO still accepts a push
  assign do_pop    = pop & ~empty & ~clr;
  assign do_push   = push & (~full | pop) & ~clr;
  assign overflow  = push & full & ~pop & ~clr;
  assign underflow = pop & empty & ~clr;

  assign rdata = empty ? '0 : mem[rd_ptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = bump(wr_ptr_q);
      if (do_pop)  rd_ptr_d = bump(rd_ptr_q);
      count_d = count_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wdata;
  end
endmodule

// File: rtl/arx_irq.sv
module arx_irq #(
  parameter int                NUM     = 6,
  parameter logic [NUM-1:0]    LATCHED = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [NUM-1:0] cond,
  input  logic           set_we,
  input  logic           clr_we,
  input  logic [NUM-1:0] wbits,
  input  logic           sts_rd,
  output logic [NUM-1:0] status,
  output logic [NUM-1:0] mask,
  output logic           irq
);
  logic [NUM-1:0] mask_q, mask_d;
  logic           mask_en;

  assign mask_en = set_we | clr_we;

  always_comb begin
    mask_d = mask_q;
    if (set_we)      mask_d = mask_q | wbits;
    else if (clr_we) mask_d = mask_q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  for (genvar i = 0; i < NUM; i++) begin : g_bit
    if (LATCHED[i]) begin : g_latch
      logic flag_q, flag_d;
      // an event arriving with the clearing read wins
      always_comb begin
        if (clr) flag_d = 1'b0;
        else     flag_d = cond[i] | (flag_q & ~sts_rd);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
      end
      assign status[i] = flag_q;
    end else begin : g_level
      assign status[i] = cond[i];
    end
  end

  assign mask = mask_q;
  assign irq  = |(status & mask_q);
endmodule

// File: rtl/audio_rx_fifo_irq.sv
module audio_rx_fifo_irq
  import arx_pkg::*;
#(
  parameter int          DEPTH   = 16,
  parameter int          SMP_W   = 24,
  parameter int          CH_W    = 2,
  parameter logic [11:0] VERSION = 12'h2B1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [CH_W-1:0]  smp_chan,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             dma_req,
  output logic             irq
);
  localparam int TAG_W = 32 - SMP_W;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [31:0]        push_word, fifo_rdata;
  logic [CW-1:0]      fifo_count;
  logic               fifo_full, fifo_empty, fifo_ovf, fifo_udf;
  logic               soft_clr, hold_rd, sts_rd, ien_we, idis_we;
  logic [CHUNK_W-1:0] chunk_q, chunk_d;
  logic               chunk_en, chunk_hit;
  logic [31:0]        thr_words, cnt_words;
  logic [NUM_EVT-1:0] ev_cond, irq_status, irq_mask;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata[CHUNK_LSB-1:NUM_EVT];

  assign push_word = {TAG_W'(smp_chan), smp_data};

  assign soft_clr = reg_wr & (reg_addr == OFS_CTRL) & reg_wdata[0];
  assign ien_we   = reg_wr & (reg_addr == OFS_IEN);
  assign idis_we  = reg_wr & (reg_addr == OFS_IDIS);
  assign chunk_en = reg_wr & (reg_addr == OFS_MODE);
  assign hold_rd  = reg_rd & (reg_addr == OFS_HOLD);
  assign sts_rd   = reg_rd & (reg_addr == OFS_ISTS);

  assign chunk_d = reg_wdata[CHUNK_LSB +: CHUNK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chunk_q <= CHUNK_W'(1);
    else if (chunk_en) chunk_q <= chunk_d;
  end

  assign thr_words = (chunk_q == '0) ? 32'd1 : 32'(chunk_q);
  assign cnt_words = 32'(fifo_count);
  assign chunk_hit = (cnt_words >= thr_words);
  assign dma_req   = chunk_hit;

  arx_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (soft_clr),
    .push      (smp_valid),
    .pop       (hold_rd),
    .wdata     (push_word),
    .rdata     (fifo_rdata),
    .count     (fifo_count),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .overflow  (fifo_ovf),
    .underflow (fifo_udf)
  );

  always_comb begin
    ev_cond           = '0;
    ev_cond[EV_READY] = ~fifo_empty;
    ev_cond[EV_EMPTY] = fifo_empty;
    ev_cond[EV_FULL]  = fifo_full;
    ev_cond[EV_CHUNK] = chunk_hit;
    ev_cond[EV_UNDER] = fifo_udf;
    ev_cond[EV_OVER]  = fifo_ovf;
  end

  arx_irq #(.NUM(NUM_EVT), .LATCHED(EV_LATCHED)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (soft_clr),
    .cond   (ev_cond),
    .set_we (ien_we),
    .clr_we (idis_we),
    .wbits  (reg_wdata[NUM_EVT-1:0]),
    .sts_rd (sts_rd),
    .status (irq_status),
    .mask   (irq_mask),
    .irq    (irq)
  );

  always_comb begin
    case (reg_addr)
      OFS_MODE: reg_rdata = {chunk_q, {CHUNK_LSB{1'b0}}};
      OFS_HOLD: reg_rdata = fifo_rdata;
      OFS_IMSK: reg_rdata = {{(32-NUM_EVT){1'b0}}, irq_mask};
      OFS_ISTS: reg_rdata = {{(32-NUM_EVT){1'b0}}, irq_status};
      OFS_VER:  reg_rdata = {20'd0, VERSION};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/arx_checker.sv
module arx_checker
  import arx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [7:0]         reg_addr,
  input logic [31:0]        reg_wdata,
  input logic               smp_valid,
  input logic               fifo_full,
  input logic [CW-1:0]      fifo_count,
  input logic [NUM_EVT-1:0] irq_mask,
  input logic [NUM_EVT-1:0] irq_status,
  input logic               dma_req,
  input logic               irq
);
  a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_IEN) |=>
      ((irq_mask & $past(reg_wdata[NUM_EVT-1:0])) == $past(reg_wdata[NUM_EVT-1:0])));

  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_IDIS) |=>
      ((irq_mask & $past(reg_wdata[NUM_EVT-1:0])) == '0));

  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> !irq);

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fifo_count) <= DEPTH));

  a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fifo_full && !(reg_rd && reg_addr == OFS_HOLD)
     && !(reg_wr && reg_addr == OFS_CTRL && reg_wdata[0])) |=> irq_status[EV_OVER]);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_ISTS && !smp_valid) |=> (irq_status[EV_OVER:EV_UNDER] == 2'b00));

  a_r10_dma_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !irq_status[EV_EMPTY]);

  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CTRL && reg_wdata[0]) |=>
      (fifo_count == '0 && irq_status[EV_OVER:EV_UNDER] == 2'b00));
endmodule

bind audio_rx_fifo_irq arx_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .smp_valid  (smp_valid),
  .fifo_full  (fifo_full),
  .fifo_count (fifo_count),
  .irq_mask   (irq_mask),
  .irq_status (irq_status),
  .dma_req    (dma_req),
  .irq        (irq)
);

// File: tb/sim_audio_rx_fifo_irq.sv
module sim_audio_rx_fifo_irq;
  localparam int CLK_P = 10;
  localparam logic [11:0] VER = 12'h2B1;

  logic        clk, rst_n;
  logic        smp_valid;
  logic [1:0]  smp_chan;
  logic [23:0] smp_data;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        dma_req, irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  audio_rx_fifo_irq #(.DEPTH(16), .SMP_W(24), .CH_W(2), .VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req), .irq(irq)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mkw(input logic [1:0] ch, input logic [23:0] s);
    return {6'd0, ch, s};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  task automatic push(input logic [1:0] ch, input logic [23:0] s);
    @(negedge clk);
    smp_valid = 1; smp_chan = ch; smp_data = s;
    @(posedge clk); #1;
    smp_valid = 0;
  endtask

  task automatic push_rd(input logic [1:0] ch, input logic [23:0] s, output logic [31:0] d);
    @(negedge clk);
    smp_valid = 1; smp_chan = ch; smp_data = s;
    reg_rd = 1; reg_addr = 8'h0C;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    smp_valid = 0; reg_rd = 0;
  endtask

  task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic expect_pins(input string tag, input logic ei, input logic ed);
    @(negedge clk); #1;
    check({tag, " irq"}, {31'd0, irq}, {31'd0, ei});
    check({tag, " dma_req"}, {31'd0, dma_req}, {31'd0, ed});
  endtask

  task automatic t_reset;
    expect_reg("R1 status", 8'h20, 32'h02);
    expect_reg("R1 mask", 8'h1C, 32'h00);
    expect_reg("R1 mode", 8'h04, 32'h1000_0000);
    expect_pins("R1", 0, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(8'h14, 32'h03);
    expect_reg("R2 set", 8'h1C, 32'h03);
    wr(8'h14, 32'h20);
    expect_reg("R2 set keeps", 8'h1C, 32'h23);
    wr(8'h18, 32'h01);
    expect_reg("R3 clear", 8'h1C, 32'h22);
    expect_pins("R4 empty enabled", 1, 0);
    wr(8'h18, 32'h3F);
    expect_reg("R3 clear all", 8'h1C, 32'h00);
    expect_pins("R4 all masked", 0, 0);
    wr(8'h14, 32'h01);
    expect_pins("R4 ready masked on but empty", 0, 0);
    push(2'd2, 24'h00_0042);
    expect_pins("R4 ready", 1, 1);
    rd(8'h0C, v);
    check("R5 single word", v, mkw(2'd2, 24'h00_0042));
    expect_pins("R4 drained", 0, 0);
    wr(8'h18, 32'h3F);
  endtask

  task automatic t_order;
    logic [31:0] v;
    push(2'd0, 24'h12_3456);
    push(2'd1, 24'h80_0001);
    push(2'd3, 24'hFF_FFFF);
    rd(8'h0C, v); check("R5 first", v, mkw(2'd0, 24'h12_3456));
    rd(8'h0C, v); check("R5 second", v, mkw(2'd1, 24'h80_0001));
    rd(8'h0C, v); check("R5 third", v, mkw(2'd3, 24'hFF_FFFF));
    expect_reg("R5 empty after", 8'h20, 32'h02);
  endtask

  task automatic t_chunk;
    logic [31:0] v;
    wr(8'h04, 32'h4FFF_FFFF);
    expect_reg("R10 mode field only", 8'h04, 32'h4000_0000);
    for (int i = 0; i < 3; i++) push(2'(i), 24'(i + 1));
    expect_pins("R10 below chunk", 0, 0);
    expect_reg("R10 status below", 8'h20, 32'h01);
    push(2'd3, 24'd4);
    expect_pins("R10 chunk reached", 0, 1);
    expect_reg("R10 status chunk", 8'h20, 32'h09);
    wr(8'h04, 32'h0000_0000);
    for (int i = 0; i < 4; i++) rd(8'h0C, v);
    expect_pins("R10 drained", 0, 0);
    push(2'd1, 24'd9);
    expect_pins("R10 zero acts as one", 0, 1);
    rd(8'h0C, v);
    wr(8'h04, 32'h8000_0000);
  endtask

  task automatic t_full;
    logic [31:0] v;
    for (int i = 0; i < 16; i++) push(2'(i % 4), 24'(i * 24'h010101));
    expect_reg("R6 full status", 8'h20, 32'h0D);
    push(2'd2, 24'hAB_CDEF);
    expect_reg("R7 overrun set", 8'h20, 32'h2D);
    push_rd(2'd1, 24'h55_AA55, v);
    check("R7 pop with push word", v, mkw(2'd0, 24'h00_0000));
    expect_reg("R7 no overrun with pop", 8'h20, 32'h0D);
    for (int i = 1; i < 16; i++) begin
      rd(8'h0C, v);
      check("R6 drain order", v, mkw(2'(i % 4), 24'(i * 24'h010101)));
    end
    rd(8'h0C, v);
    check("R7 accepted push", v, mkw(2'd1, 24'h55_AA55));
    expect_reg("R6 drained", 8'h20, 32'h02);
  endtask

  task automatic t_under;
    logic [31:0] v;
    rd(8'h0C, v);
    check("R8 empty read zero", v, 32'h0);
    expect_reg("R8 underrun set", 8'h20, 32'h12);
    expect_reg("R9 cleared by read", 8'h20, 32'h02);
    push_rd(2'd3, 24'h7F_0000, v);
    check("R8 empty pop with push", v, 32'h0);
    expect_reg("R8 push kept", 8'h20, 32'h11);
    rd(8'h0C, v);
    check("R8 stored word", v, mkw(2'd3, 24'h7F_0000));
  endtask

  task automatic t_soft;
    logic [31:0] v;
    wr(8'h14, 32'h30);
    for (int i = 0; i < 17; i++) push(2'd1, 24'(i));
    expect_pins("R11 before reset", 1, 1);
    wr(8'h00, 32'h1);
    expect_pins("R11 after reset", 0, 0);
    expect_reg("R11 status", 8'h20, 32'h02);
    expect_reg("R11 mask kept", 8'h1C, 32'h30);
    expect_reg("R11 mode kept", 8'h04, 32'h8000_0000);
    rd(8'h0C, v);
    check("R11 fifo empty", v, 32'h0);
    expect_pins("R11 underrun irq", 1, 0);
    expect_reg("R9 status before clear", 8'h20, 32'h12);
    expect_pins("R9 irq after clear", 0, 0);
  endtask

  task automatic t_misc;
    expect_reg("R12 version", 8'h50, {20'd0, VER});
    expect_reg("R12 unmapped 0x08", 8'h08, 32'h0);
    expect_reg("R12 unmapped 0x3C", 8'h3C, 32'h0);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; smp_valid = 0; smp_chan = '0; smp_data = '0;
    reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    #(CLK_P * 3);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_mask();
    t_order();
    t_chunk();
    t_full();
    t_under();
    t_soft();
    t_misc();
    done = 1;
    summary();
    $finish;
  end
endmodule